// File: doc/BRIEF.md
# Configurable Pin-to-Resource Router

This block connects eight general-purpose input pins to four internal destinations: the clock inputs of two counters and two interrupt request lines, one of high and one of low priority. Each pin has its own 3-bit routing code. The code decides which destination the pin feeds. For an interrupt destination, the code also decides whether a rising or a falling edge of the pin raises the request. When several pins feed the same destination, their contributions are combined by OR.

Every pin input first passes through a two-flop synchronizer. Counter clock outputs carry the synchronized pin level, and the counter does its own edge counting. Interrupt outputs are pulses one cycle wide, one pulse for each qualifying edge. A small byte-wide register port holds the routing codes and the pin-direction bits. A direction bit turns on a pin's output enable only while that pin has no route.

Top module: `pinrt_router`

## Requirements
- R1: After reset, every routing code and every direction bit is zero. All register reads return 0x00, and cnt0_clk, cnt1_clk, irq_hi, irq_lo and pin_oe are all 0.
- R2: A pin with code 0 (no route) or code 1 (reserved) has no effect on cnt0_clk, cnt1_clk, irq_hi or irq_lo.
- R3: With code 2, cnt0_clk follows the pin's level. With code 3, cnt1_clk follows the pin's level. A level applied before clock edge k appears at the output after edge k+1.
- R4: With code 4 (irq_hi) or code 5 (irq_lo), a rising pin edge gives a pulse one cycle wide on that line. The pulse is high in the cycle after edge k+1, when the new level was applied before edge k.
- R5: With code 6 (irq_hi) or code 7 (irq_lo), a falling pin edge gives a pulse one cycle wide, with the same timing as R4.
- R6: Each of the four outputs is the OR of the contributions of every pin whose code selects it.
- R7: Register map. Address a (0 to 3) holds the code of pin 2a in bits [2:0] and the code of pin 2a+1 in bits [6:4]. Bits 3 and 7 read as 0. Address 4 holds the direction bits, with bit i for pin i. Reads of addresses 5 to 7 return 0, and writes to them change nothing. A write with cfg_we takes effect at the next clock edge. cfg_rdata shows the addressed byte combinationally.
- R8: pin_oe[i] is 1 exactly when direction bit i is 1 and pin i has code 0. The direction bit is ignored for a pin that has a route.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register byte address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the addressed register |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_oe | output | 8 | Output enable for each pin |
| cnt0_clk | output | 1 | Clock input for counter 0 |
| cnt1_clk | output | 1 | Clock input for counter 1 |
| irq_hi | output | 1 | High-priority interrupt pulse |
| irq_lo | output | 1 | Low-priority interrupt pulse |

## Verification
The hardest case to reach from the ports is several pins feeding one interrupt line with mixed polarities, so that one pin rises while another falls in the same cycle. A second hard case is a routing code that is rewritten while an edge is still moving through the synchronizer. Directed phases set up fan-in of all pins to one line and edges that occur together. A long random phase then rewrites routing bytes at random while sparse random pin toggles are applied. This produces code changes in the middle of the synchronizer delay and mixed-edge merges.

// File: rtl/pinrt_pkg.sv
package pinrt_pkg;
    localparam int unsigned NPIN   = 8;
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [SEL_W-1:0] {
        RT_NONE    = 3'd0,
        RT_RSVD    = 3'd1,
        RT_CNT0    = 3'd2,
        RT_CNT1    = 3'd3,
        RT_HI_RISE = 3'd4,
        RT_LO_RISE = 3'd5,
        RT_HI_FALL = 3'd6,
        RT_LO_FALL = 3'd7
    } route_e;
endpackage

// File: rtl/pinrt_cfg.sv
module pinrt_cfg #(
    parameter int unsigned NPIN   = pinrt_pkg::NPIN,
    parameter int unsigned ADDR_W = pinrt_pkg::ADDR_W,
    parameter int unsigned DATA_W = pinrt_pkg::DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [NPIN-1:0][2:0]   sel,
    output logic [NPIN-1:0]        dir,
    output logic [DATA_W-1:0]      rdata
);
    localparam int unsigned NREG     = NPIN / 2;
    localparam int unsigned DIR_ADDR = NREG;

    typedef struct packed {
        logic [NPIN-1:0][2:0] sel;
        logic [NPIN-1:0]      dir;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            for (int r = 0; r < NREG; r++) begin
                if (addr == ADDR_W'(r)) begin
                    st_d.sel[2*r]   = wdata[2:0];
                    st_d.sel[2*r+1] = wdata[6:4];
                end
            end
            if (addr == ADDR_W'(DIR_ADDR)) begin
                st_d.dir = wdata[NPIN-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        for (int r = 0; r < NREG; r++) begin
            if (addr == ADDR_W'(r)) begin
                rdata = DATA_W'({1'b0, st_q.sel[2*r+1], 1'b0, st_q.sel[2*r]});
            end
        end
        if (addr == ADDR_W'(DIR_ADDR)) begin
            rdata[NPIN-1:0] = st_q.dir;
        end
    end

    assign sel = st_q.sel;
    assign dir = st_q.dir;
endmodule

// File: rtl/pinrt_sync.sv
module pinrt_sync #(
    parameter int unsigned NPIN = pinrt_pkg::NPIN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] lvl,
    output logic [NPIN-1:0] prev
);
    typedef struct packed {
        logic [NPIN-1:0] s1;
        logic [NPIN-1:0] s2;
        logic [NPIN-1:0] pv;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = pin_in;
        st_d.s2 = st_q.s1;
        st_d.pv = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl  = st_q.s2;
    assign prev = st_q.pv;
endmodule

// File: rtl/pinrt_route.sv
module pinrt_route
    import pinrt_pkg::*;
#(
    parameter int unsigned NPIN = pinrt_pkg::NPIN
) (
    input  logic [NPIN-1:0][2:0] sel,
    input  logic [NPIN-1:0]      dir,
    input  logic [NPIN-1:0]      lvl,
    input  logic [NPIN-1:0]      prev,
    output logic [NPIN-1:0]      oe,
    output logic                 cnt0,
    output logic                 cnt1,
    output logic                 irq_hi,
    output logic                 irq_lo
);
    logic [NPIN-1:0] hit_c0, hit_c1, hit_hi, hit_lo;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic rise, fall;
        assign rise      = lvl[g] & ~prev[g];
        assign fall      = ~lvl[g] & prev[g];
        assign hit_c0[g] = (sel[g] == RT_CNT0) & lvl[g];
        assign hit_c1[g] = (sel[g] == RT_CNT1) & lvl[g];
        assign hit_hi[g] = ((sel[g] == RT_HI_RISE) & rise) | ((sel[g] == RT_HI_FALL) & fall);
        assign hit_lo[g] = ((sel[g] == RT_LO_RISE) & rise) | ((sel[g] == RT_LO_FALL) & fall);
        assign oe[g]     = dir[g] & (sel[g] == RT_NONE);
    end

    assign cnt0   = |hit_c0;
    assign cnt1   = |hit_c1;
    assign irq_hi = |hit_hi;
    assign irq_lo = |hit_lo;
endmodule

// File: rtl/pinrt_router.sv
module pinrt_router #(
    parameter int unsigned NPIN   = pinrt_pkg::NPIN,
    parameter int unsigned ADDR_W = pinrt_pkg::ADDR_W,
    parameter int unsigned DATA_W = pinrt_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_oe,
    output logic              cnt0_clk,
    output logic              cnt1_clk,
    output logic              irq_hi,
    output logic              irq_lo
);
    logic [NPIN-1:0][2:0] sel;
    logic [NPIN-1:0]      dir;
    logic [NPIN-1:0]      lvl;
    logic [NPIN-1:0]      prev;

    pinrt_cfg #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .sel   (sel),
        .dir   (dir),
        .rdata (cfg_rdata)
    );

    pinrt_sync #(.NPIN(NPIN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .lvl    (lvl),
        .prev   (prev)
    );

    pinrt_route #(.NPIN(NPIN)) u_route (
        .sel    (sel),
        .dir    (dir),
        .lvl    (lvl),
        .prev   (prev),
        .oe     (pin_oe),
        .cnt0   (cnt0_clk),
        .cnt1   (cnt1_clk),
        .irq_hi (irq_hi),
        .irq_lo (irq_lo)
    );
endmodule

// File: rtl/pinrt_checker.sv
module pinrt_checker #(
    parameter int unsigned NPIN   = pinrt_pkg::NPIN,
    parameter int unsigned ADDR_W = pinrt_pkg::ADDR_W,
    parameter int unsigned DATA_W = pinrt_pkg::DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [NPIN-1:0]   pin_oe,
    input logic              cnt0_clk,
    input logic              cnt1_clk,
    input logic              irq_hi,
    input logic              irq_lo,
    input logic [NPIN-1:0]   lvl,
    input logic [NPIN-1:0]   prev,
    input logic [NPIN-1:0]   dir
);
    localparam int unsigned DIR_ADDR = NPIN / 2;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir == '0 && pin_oe == '0 && !cnt0_clk && !cnt1_clk && !irq_hi && !irq_lo)); // R1
    AST_CNT_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt0_clk || cnt1_clk) |-> (lvl != '0)); // R3
    AST_IRQ_HI_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (lvl != prev)); // R4
    AST_IRQ_LO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (lvl != prev)); // R5
    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_W'(DIR_ADDR)) |=> (dir == $past(cfg_wdata[NPIN-1:0]))); // R7
    AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~dir) == '0); // R8
endmodule

bind pinrt_router pinrt_checker #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pinrt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pin_oe    (pin_oe),
    .cnt0_clk  (cnt0_clk),
    .cnt1_clk  (cnt1_clk),
    .irq_hi    (irq_hi),
    .irq_lo    (irq_lo),
    .lvl       (lvl),
    .prev      (prev),
    .dir       (dir)
);

// File: tb/test_pinrt_router.sv
`timescale 1ns/1ps
module test_pinrt_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_oe;
    logic       cnt0_clk, cnt1_clk, irq_hi, irq_lo;

    int errors = 0;
    int checks = 0;

    logic [2:0] m_sel [8];
    logic [7:0] m_dir = '0;
    logic [7:0] m_s1 = '0, m_s2 = '0, m_pv = '0;

    always #10 clk = ~clk;

    pinrt_router i_pinrt_router (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .cnt0_clk(cnt0_clk), .cnt1_clk(cnt1_clk),
        .irq_hi(irq_hi), .irq_lo(irq_lo)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        if (a < 3'd4) return {1'b0, m_sel[2*a+1], 1'b0, m_sel[2*a]};
        if (a == 3'd4) return m_dir;
        return 8'h00;
    endfunction

    // Expected outputs: {irq_lo, irq_hi, cnt1, cnt0}
    function automatic logic [3:0] exp_out();
        logic [3:0] o = '0;
        for (int i = 0; i < 8; i++) begin
            logic r, f;
            r = m_s2[i] & ~m_pv[i];
            f = ~m_s2[i] & m_pv[i];
            case (m_sel[i])
                3'd2: o[0] |= m_s2[i];
                3'd3: o[1] |= m_s2[i];
                3'd4: o[2] |= r;
                3'd5: o[3] |= r;
                3'd6: o[2] |= f;
                3'd7: o[3] |= f;
                default: ;
            endcase
        end
        return o;
    endfunction

    function automatic logic [7:0] exp_oe();
        logic [7:0] e;
        for (int i = 0; i < 8; i++) e[i] = m_dir[i] & (m_sel[i] == 3'd0);
        return e;
    endfunction

    task automatic check_all(input string tag);
        logic [3:0] o;
        o = exp_out();
        chk({tag, " cnt0"}, {7'd0, cnt0_clk}, {7'd0, o[0]});
        chk({tag, " cnt1"}, {7'd0, cnt1_clk}, {7'd0, o[1]});
        chk({tag, " irq_hi"}, {7'd0, irq_hi}, {7'd0, o[2]});
        chk({tag, " irq_lo"}, {7'd0, irq_lo}, {7'd0, o[3]});
        chk("R8 pin_oe", pin_oe, exp_oe());
        chk("R7 readback", cfg_rdata, exp_rd(cfg_addr));
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        m_pv = m_s2;
        m_s2 = m_s1;
        m_s1 = pin_in;
        if (cfg_we) begin
            if (cfg_addr < 3'd4) begin
                m_sel[2*cfg_addr]   = cfg_wdata[2:0];
                m_sel[2*cfg_addr+1] = cfg_wdata[6:4];
            end else if (cfg_addr == 3'd4) begin
                m_dir = cfg_wdata;
            end
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick("R7");
        cfg_we = 1'b0;
    endtask

    task automatic run(input string tag, input int n);
        for (int k = 0; k < n; k++) tick(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) m_sel[i] = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on every address and output
        for (int a = 0; a < 8; a++) begin
            cfg_addr = 3'(a);
            #1;
            chk("R1 rdata", cfg_rdata, 8'h00);
        end
        chk("R1 outs", {pin_oe}, 8'h00);
        chk("R1 lines", {4'd0, irq_lo, irq_hi, cnt1_clk, cnt0_clk}, 8'h00);
        run("R1", 2);

        // R2: codes 0 and 1 leave every destination idle
        wr(3'd0, 8'h10); wr(3'd1, 8'h01); wr(3'd2, 8'h11); wr(3'd3, 8'h00);
        wr(3'd4, 8'hFF);
        pin_in = 8'hFF; run("R2", 4);
        pin_in = 8'h00; run("R2", 4);

        // R3: counter clocks follow level
        wr(3'd0, 8'h32);
        pin_in = 8'h01; run("R3", 4);
        pin_in = 8'h03; run("R3", 4);
        pin_in = 8'h00; run("R3", 4);

        // R4: rising-edge interrupts
        wr(3'd1, 8'h54);
        pin_in = 8'h0C; run("R4", 4);
        // R5: falling-edge interrupts
        wr(3'd2, 8'h76);
        pin_in = 8'h30; run("R5", 4);
        pin_in = 8'h00; run("R5", 4);

        // R6: all pins fan into irq_hi, mixed polarities at once
        wr(3'd0, 8'h64); wr(3'd1, 8'h64); wr(3'd2, 8'h64); wr(3'd3, 8'h64);
        pin_in = 8'h55; run("R6", 3);
        pin_in = 8'hAA; run("R6", 3);
        pin_in = 8'hFF; run("R6", 3);

        // R7: writes to unused addresses change nothing
        wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        for (int a = 0; a < 8; a++) begin
            cfg_addr = 3'(a);
            #1;
            chk("R7 map", cfg_rdata, exp_rd(3'(a)));
        end

        // Random mix
        for (int k = 0; k < 4000; k++) begin
            cfg_we    = ($urandom % 6) == 0;
            cfg_addr  = 3'($urandom % 8);
            cfg_wdata = 8'($urandom);
            pin_in    = pin_in ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
            tick("R6");
        end
        cfg_we = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule